// File: doc/BRIEF.md
# Prefix-Extended Instruction Decoder

This block is the fetch-and-decode stage of a byte-coded stack processor. Every instruction byte carries a 4-bit function code in its upper nibble and a 4-bit data nibble in its lower nibble. The decoder keeps an operand register. Each accepted byte ORs its data nibble into that register. Two function codes, prefix and negative prefix, emit nothing. They only extend the operand four bits at a time, so operands of any length can be built. Every other function code emits one decoded instruction, made of the function code and the full operand, and then clears the operand register.

One function code is the indirect "operate" function. For it, the operand value acts as the number of a secondary operation. The block flags these instructions and reports whether the secondary number falls inside the supported range. Building the operand is the same at any word width, so one byte stream decodes to the same low-order operand bits on a 16-bit datapath and on a 32-bit datapath.

Bytes arrive on a valid/ready stream, and decoded instructions leave on another valid/ready stream through a single output register. A byte is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. The rule is the same for every kind of byte. An output that is held by a low `out_ready` keeps all of its fields steady until it is taken.

Top module: `pfx_decoder`

## Requirements
- R1: After reset (`rst_n` low), `out_valid` is 0, `in_ready` is 1, and the operand register is zero. Any prefix state from before the reset is lost, so a single non-prefix byte decoded after reset carries only its own nibble as its operand.
- R2: A byte whose upper nibble is neither 0x2 nor 0x6, accepted with no preceding prefix bytes, produces the following in the cycle after acceptance: `out_valid` = 1, `out_func` = byte[7:4], and `out_operand` = byte[3:0] zero-extended.
- R3: A byte with upper nibble 0x2 (prefix) sets the operand register to (operand OR byte[3:0]) shifted left by 4 and produces no output instruction.
- R4: A byte with upper nibble 0x6 (negative prefix) sets the operand register to the bitwise complement of (operand OR byte[3:0]), shifted left by 4 and truncated to WORD_W bits. It produces no output instruction.
- R5: Every emitted instruction carries `out_operand` = (operand register OR its own nibble). After the emit the operand register is zero, so the next instruction starts with an empty operand.
- R6: `out_indirect` is 1 exactly when `out_func` = 0xF. `out_ext_legal` is 1 exactly when `out_indirect` = 1 and `out_operand` < EXT_COUNT (default 112). Both are 0 for every other function code.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0. In that state no byte is taken, and `out_func`, `out_operand`, `out_indirect` and `out_ext_legal` hold their values.
- R8: Bits shifted above WORD_W are discarded. The low 16 bits of any operand are identical for WORD_W = 16 and WORD_W = 32 given the same bytes.
- R9: With `out_ready` held at 1, `in_ready` stays at 1 and one byte is accepted every cycle, with one instruction emitted per non-prefix byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_byte | input | 8 | Function code [7:4], data nibble [3:0] |
| out_valid | output | 1 | Decoded instruction present |
| out_ready | input | 1 | Consumer takes the instruction this cycle |
| out_func | output | 4 | Primary function code |
| out_operand | output | WORD_W | Fully built operand |
| out_indirect | output | 1 | Instruction is the indirect operate function |
| out_ext_legal | output | 1 | Indirect and secondary number in range |

## Verification
The bench builds two copies of the decoder side by side from one byte stream: one with WORD_W = 32 and one with WORD_W = 16, both with the default EXT_COUNT of 112. Running both on the same stream shows that negative-prefix chains such as -1 and -24 give matching low bits at both widths. It also shows that bits shifted past the top of the narrower register are dropped. The secondary-number vectors sit at 111 and 112, which exercises the range boundary of the operate function at both widths.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    KIND_EMIT = 2'd0,
    KIND_PFX  = 2'd1,
    KIND_NFX  = 2'd2
  } byte_kind_e;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_dec_pkg::*;
#(
  parameter logic [NIB_W-1:0] PFX_CODE = 4'h2,
  parameter logic [NIB_W-1:0] NFX_CODE = 4'h6,
  parameter logic [NIB_W-1:0] OPR_CODE = 4'hF
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [NIB_W-1:0]  func_o,
  output logic [NIB_W-1:0]  nib_o,
  output byte_kind_e        kind_o,
  output logic              indirect_o
);
  always_comb begin
    func_o     = byte_i[BYTE_W-1:NIB_W];
    nib_o      = byte_i[NIB_W-1:0];
    indirect_o = (func_o == OPR_CODE);
    if (func_o == PFX_CODE)      kind_o = KIND_PFX;
    else if (func_o == NFX_CODE) kind_o = KIND_NFX;
    else                         kind_o = KIND_EMIT;
  end
endmodule

// File: rtl/pfx_operand_acc.sv
module pfx_operand_acc
  import pfx_dec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  byte_kind_e        kind_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [WORD_W-1:0] merged_o
);
  localparam int PAD_W = WORD_W - NIB_W;

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_d;

  always_comb begin
    merged_o = acc_q | {{PAD_W{1'b0}}, nib_i};
    acc_d    = acc_q;
    if (take_i) begin
      unique case (kind_i)
        KIND_PFX: acc_d = merged_o << NIB_W;
        KIND_NFX: acc_d = (~merged_o) << NIB_W;
        default:  acc_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_PFX_LOW_NIB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && (kind_i != KIND_EMIT) |=> acc_q[NIB_W-1:0] == '0); // R3

  AST_EMIT_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && (kind_i == KIND_EMIT) |=> acc_q == '0); // R5

  AST_IDLE_ACC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(acc_q)); // R7
endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage
  import pfx_dec_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int EXT_COUNT = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [NIB_W-1:0]  func_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic              indirect_i,
  output logic              slot_free_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NIB_W-1:0]  out_func,
  output logic [WORD_W-1:0] out_operand,
  output logic              out_indirect,
  output logic              out_ext_legal
);
  localparam logic [WORD_W-1:0] EXT_LIMIT = WORD_W'(EXT_COUNT);

  logic legal_d;

  always_comb begin
    slot_free_o = !out_valid || out_ready;
    legal_d     = indirect_i && (operand_i < EXT_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_func      <= '0;
      out_operand   <= '0;
      out_indirect  <= 1'b0;
      out_ext_legal <= 1'b0;
    end else if (load_i) begin
      out_valid     <= 1'b1;
      out_func      <= func_i;
      out_operand   <= operand_i;
      out_indirect  <= indirect_i;
      out_ext_legal <= legal_d;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_func) &&
      $stable(out_operand) && $stable(out_indirect) && $stable(out_ext_legal)); // R7

  AST_LEGAL_NEEDS_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ext_legal |-> out_indirect); // R6
endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
  import pfx_dec_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int EXT_COUNT = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_func,
  output logic [WORD_W-1:0] out_operand,
  output logic              out_indirect,
  output logic              out_ext_legal
);
  logic [NIB_W-1:0]  func_w;
  logic [NIB_W-1:0]  nib_w;
  byte_kind_e        kind_w;
  logic              indirect_w;
  logic              take_w;
  logic              slot_free_w;
  logic [WORD_W-1:0] merged_w;

  pfx_classify u_classify (
    .byte_i     (in_byte),
    .func_o     (func_w),
    .nib_o      (nib_w),
    .kind_o     (kind_w),
    .indirect_o (indirect_w)
  );

  always_comb begin
    in_ready = slot_free_w;
    take_w   = in_valid && slot_free_w;
  end

  pfx_operand_acc #(.WORD_W(WORD_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take_w),
    .kind_i   (kind_w),
    .nib_i    (nib_w),
    .merged_o (merged_w)
  );

  pfx_out_stage #(.WORD_W(WORD_W), .EXT_COUNT(EXT_COUNT)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (take_w && (kind_w == KIND_EMIT)),
    .func_i        (func_w),
    .operand_i     (merged_w),
    .indirect_i    (indirect_w),
    .slot_free_o   (slot_free_w),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_func      (out_func),
    .out_operand   (out_operand),
    .out_indirect  (out_indirect),
    .out_ext_legal (out_ext_legal)
  );

  AST_BLOCKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_byte[7:4] == 4'h2 || in_byte[7:4] == 4'h6) && out_ready
      |=> !out_valid); // R4

  AST_EMIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_byte[7:4] != 4'h2 && in_byte[7:4] != 4'h6
      |=> out_valid && out_func == $past(in_byte[7:4])); // R2

  AST_INDIRECT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_indirect == (out_func == 4'hF)); // R6

  AST_READY_WHEN_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R9
endmodule

// File: tb/tb_pfx_decoder.sv
module tb_pfx_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_ready = 1'b1;
  logic        in_ready, in_ready16;
  logic        out_valid, out_valid16;
  logic [3:0]  out_func, out_func16;
  logic [31:0] out_operand;
  logic [15:0] out_operand16;
  logic        out_indirect, out_indirect16;
  logic        out_ext_legal, out_ext_legal16;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #10 clk = ~clk;

  pfx_decoder #(.WORD_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_func(out_func), .out_operand(out_operand),
    .out_indirect(out_indirect), .out_ext_legal(out_ext_legal));

  pfx_decoder #(.WORD_W(16)) dut16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready16),
    .in_byte(in_byte), .out_valid(out_valid16), .out_ready(out_ready),
    .out_func(out_func16), .out_operand(out_operand16),
    .out_indirect(out_indirect16), .out_ext_legal(out_ext_legal16));

  // entry: {byte[8], emits[1], func[4], operand32[32]}
  localparam int NV = 21;
  localparam logic [44:0] VEC [NV] = '{
    {8'h45, 1'b1, 4'h4, 32'h0000_0005},
    {8'h2A, 1'b0, 4'h0, 32'h0},
    {8'h13, 1'b1, 4'h1, 32'h0000_00A3},
    {8'h21, 1'b0, 4'h0, 32'h0},
    {8'h22, 1'b0, 4'h0, 32'h0},
    {8'h7F, 1'b1, 4'h7, 32'h0000_012F},
    {8'h60, 1'b0, 4'h0, 32'h0},
    {8'h4F, 1'b1, 4'h4, 32'hFFFF_FFFF},
    {8'h61, 1'b0, 4'h0, 32'h0},
    {8'h08, 1'b1, 4'h0, 32'hFFFF_FFE8},
    {8'h2F, 1'b0, 4'h0, 32'h0},
    {8'h65, 1'b0, 4'h0, 32'h0},
    {8'h30, 1'b1, 4'h3, 32'hFFFF_F0A0},
    {8'hF3, 1'b1, 4'hF, 32'h0000_0003},
    {8'h26, 1'b0, 4'h0, 32'h0},
    {8'hF0, 1'b1, 4'hF, 32'h0000_0060},
    {8'h27, 1'b0, 4'h0, 32'h0},
    {8'hF0, 1'b1, 4'hF, 32'h0000_0070},
    {8'h26, 1'b0, 4'h0, 32'h0},
    {8'hFF, 1'b1, 4'hF, 32'h0000_006F},
    {8'h00, 1'b1, 4'h0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_instr(input string req, input logic [3:0] f, input logic [31:0] op);
    logic [15:0] op16 = op[15:0];
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " func"}, 32'(out_func), 32'(f));
    chk({req, " operand"}, out_operand, op);
    chk({req, " indirect"}, 32'(out_indirect), 32'(f == 4'hF));
    chk({req, " legal"}, 32'(out_ext_legal), 32'((f == 4'hF) && (op < 32'd112)));
    chk({req, " R8 valid16"}, 32'(out_valid16), 32'd1);
    chk({req, " R8 operand16"}, 32'(out_operand16), 32'(op16));
    chk({req, " R8 legal16"}, 32'(out_ext_legal16), 32'((f == 4'hF) && (op16 < 16'd112)));
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v = VEC[i];
      send(v[44:37]);
      if (v[36]) chk_instr($sformatf("R2 R5 R6 vec%0d", i), v[35:32], v[31:0]);
      else begin
        chk($sformatf("R3 R4 no emit vec%0d", i), 32'(out_valid), 32'd0);
        chk($sformatf("R3 R4 no emit16 vec%0d", i), 32'(out_valid16), 32'd0);
      end
    end

    // R9 back-to-back throughput
    in_valid = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      in_byte = 8'h10 | 8'(k);
      @(negedge clk);
      chk("R9 in_ready", 32'(in_ready), 32'd1);
      chk_instr("R9 streaming", 4'h1, 32'(k));
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R7 back-pressure
    out_ready = 1'b0;
    send(8'h51);
    chk_instr("R7 stalled", 4'h5, 32'h1);
    in_valid = 1'b1;
    in_byte  = 8'h22;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 in_ready low", 32'(in_ready), 32'd0);
      chk_instr("R7 held", 4'h5, 32'h1);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 drained", 32'(out_valid), 32'd0);
    send(8'h31);
    chk_instr("R7 blocked prefix not taken", 4'h3, 32'h1);

    // R1 reset discards prefix state
    send(8'h2F);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h41);
    chk_instr("R1 operand cleared", 4'h4, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule